// File: doc/BRIEF.md
# Three-Phase PWM Generator with Shared Period Counter

This block drives three PWM phases from one up-counter. The counter starts at zero and returns to zero after it reaches a programmed period value. Each phase has its own duty threshold. A phase is active from the cycle in which the counter restarts until the counter reaches that threshold, and it stays inactive for the rest of the period. Each phase drives a pair of pins: one carries the phase level and the other carries its inverse. This gives six pin drivers, and each pin has its own output-enable bit.

Settings are loaded through a simple write port: the period, the three duty thresholds, a run/stop bit, the six pin enables and a polarity bit for the pins. An active-low trip input stops the block from driving its pins. The input is first passed through two synchronizing flops. A falling edge on it then sets a sticky fault flag, which puts all six pins into high impedance. Software clears the flag, and a clear is accepted only while the synchronized trip input is high.

Top module: `pwm3_top`

## Requirements
- R1: While running, the counter goes 0, 1, …, P and then back to 0, where P is the period register (write address 0). Consecutive rising edges of an active phase are therefore P+1 cycles apart, and all phases rise in the same cycle.
- R2: For a duty value D with 0 < D < P, phase k is active for exactly D of every P+1 cycles. Duty for phase k is written at address 1+k, for k = 0, 1, 2.
- R3: Output bit 3+k is always the inverse of output bit k. Bits 0..2 are the in-phase pins of phases 0..2, and bits 3..5 are their inverse pins.
- R4: A duty of 0 keeps the phase constantly inactive. A duty equal to or greater than P keeps it constantly active, with no toggles.
- R5: Output-enable bit j (bits 5:0 written at address 5) drives pwm_oe[j] while no fault is present.
- R6: A falling edge of trip_n, taken after two synchronizing flops, drives every pwm_oe bit low within four clock cycles.
- R7: The fault is sticky. A clear request (bit 1 written at address 4) is ignored while the synchronized trip_n is low. The fault stays set after trip_n returns high, and it is released only by a clear request made while trip_n is high.
- R8: Run bit 0 at address 4 gates counting. While it is 0, the counter holds its value and every phase is at its inactive level.
- R9: Polarity bit 0 at address 6 sets the in-phase pin level: when it is 1 the pin is high when the phase is active, and when it is 0 the pin is low when the phase is active.
- R10: After reset, every register is zero except polarity, which is 1. All pwm_oe bits are low, and the in-phase pins sit at the inactive level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| trip_n | input | 1 | Asynchronous active-low trip input |
| pwm_o | output | 6 | Pin levels (bits 0..2 in-phase, 3..5 inverse) |
| pwm_oe | output | 6 | Pin drive enables (0 means high impedance) |

## Verification
The main function is tried with three duty patterns. Interior duty values test the match point of each phase separately. Duties of zero, exactly P and above P test the edges of the compare window. A short period with known rising edges tests the wrap point and checks that the phases restart together. Each pattern is measured by counting active cycles over whole periods, so an off-by-one in the compare or in the wrap shows up as a wrong count. The polarity flip, the enable mask, stopping and restarting, and the fault sequence (clear tried while the trip is low, trip released, then cleared) each test a single control path.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int ADR_PERIOD = 0;
  localparam int ADR_DUTY0  = 1;
  localparam int ADR_CTRL   = 4;
  localparam int ADR_OEN    = 5;
  localparam int ADR_LEVEL  = 6;

  // Phase level for the cycle whose counter value is nxt.
  function automatic logic duty_active(input logic [31:0] nxt,
                                       input logic [31:0] duty,
                                       input logic [31:0] period);
    if (duty == 32'd0)    return 1'b0;
    if (duty >= period)   return 1'b1;
    return (nxt < duty);
  endfunction
endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
  import pwm3_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PH_N   = 3,
  parameter int ADDR_W = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [CNT_W-1:0]               wr_data,
  output logic [CNT_W-1:0]               period_q,
  output logic [PH_N-1:0][CNT_W-1:0]     duty_q,
  output logic                           run_q,
  output logic [2*PH_N-1:0]              oen_q,
  output logic                           pol_q,
  output logic                           clr_req
);
  localparam int PIN_N = 2 * PH_N;

  logic sel_period, sel_ctrl, sel_oen, sel_level;
  assign sel_period = wr_en && (wr_addr == ADDR_W'(ADR_PERIOD));
  assign sel_ctrl   = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
  assign sel_oen    = wr_en && (wr_addr == ADDR_W'(ADR_OEN));
  assign sel_level  = wr_en && (wr_addr == ADDR_W'(ADR_LEVEL));
  assign clr_req    = sel_ctrl && wr_data[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      run_q    <= 1'b0;
      oen_q    <= '0;
      pol_q    <= 1'b1;
    end else begin
      if (sel_period) period_q <= wr_data;
      if (sel_ctrl)   run_q    <= wr_data[0];
      if (sel_oen)    oen_q    <= wr_data[PIN_N-1:0];
      if (sel_level)  pol_q    <= wr_data[0];
    end
  end

  generate
    for (genvar k = 0; k < PH_N; k++) begin : g_duty
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          duty_q[k] <= '0;
        else if (wr_en && (wr_addr == ADDR_W'(ADR_DUTY0 + k)))
          duty_q[k] <= wr_data;
      end
    end
  endgenerate
endmodule

// File: rtl/pwm3_counter.sv
module pwm3_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c,
                                            input logic [CNT_W-1:0] p);
    return (c >= p) ? '0 : c + 1'b1;
  endfunction

  assign cnt_nxt = step(cnt_q, period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase
  import pwm3_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] duty,
  input  logic [CNT_W-1:0] period,
  output logic             ph_q
);
  logic ph_d;
  assign ph_d = run && duty_active(32'(cnt_nxt), 32'(duty), 32'(period));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/pwm3_trip.sv
module pwm3_trip (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_n,
  input  logic clr_req,
  output logic fault_q,
  output logic trip_edge,
  output logic trip_hi
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= trip_n;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign trip_hi   = s2_q;
  assign trip_edge = s3_q && !s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  fault_q <= 1'b0;
    else if (trip_edge)          fault_q <= 1'b1;
    else if (clr_req && trip_hi) fault_q <= 1'b0;
  end
endmodule

// File: rtl/pwm3_top.sv
module pwm3_top #(
  parameter int CNT_W  = 16,
  parameter int PH_N   = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              trip_n,
  output logic [2*PH_N-1:0] pwm_o,
  output logic [2*PH_N-1:0] pwm_oe
);
  localparam int PIN_N = 2 * PH_N;

  logic [CNT_W-1:0]           period_q;
  logic [PH_N-1:0][CNT_W-1:0] duty_q;
  logic                       run_q, pol_q, clr_req;
  logic [PIN_N-1:0]           oen_q;
  logic [CNT_W-1:0]           cnt_q, cnt_nxt;
  logic [PH_N-1:0]            ph_q;
  logic                       fault_q, trip_edge, trip_hi;

  pwm3_regs #(.CNT_W(CNT_W), .PH_N(PH_N), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .period_q(period_q), .duty_q(duty_q),
    .run_q(run_q), .oen_q(oen_q), .pol_q(pol_q), .clr_req(clr_req)
  );

  pwm3_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .run(run_q), .period(period_q),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
  );

  generate
    for (genvar k = 0; k < PH_N; k++) begin : g_ph
      pwm3_phase #(.CNT_W(CNT_W)) ph_i (
        .clk(clk), .rst_n(rst_n), .run(run_q), .cnt_nxt(cnt_nxt),
        .duty(duty_q[k]), .period(period_q), .ph_q(ph_q[k])
      );
      assign pwm_o[k]        = pol_q ? ph_q[k] : !ph_q[k];
      assign pwm_o[k + PH_N] = !pwm_o[k];
    end
  endgenerate

  pwm3_trip trip_i (
    .clk(clk), .rst_n(rst_n), .trip_n(trip_n), .clr_req(clr_req),
    .fault_q(fault_q), .trip_edge(trip_edge), .trip_hi(trip_hi)
  );

  assign pwm_oe = oen_q & {PIN_N{!fault_q}};
endmodule

// File: rtl/pwm3_chk.sv
module pwm3_chk #(
  parameter int CNT_W = 16,
  parameter int PH_N  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  period_q,
  input logic [PH_N-1:0]   ph_q,
  input logic              trip_edge,
  input logic              trip_hi,
  input logic              fault_q,
  input logic [2*PH_N-1:0] pwm_oe
);
  // R1
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q >= period_q) |=> (cnt_q == '0));
  // R1
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q < period_q) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> $stable(cnt_q));
  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (ph_q == '0));
  // R6
  trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_edge |=> (pwm_oe == '0));
  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !trip_hi) |=> fault_q);
endmodule

bind pwm3_top pwm3_chk #(.CNT_W(CNT_W), .PH_N(PH_N)) chk_i (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .cnt_q(cnt_q),
  .period_q(period_q), .ph_q(ph_q), .trip_edge(trip_edge),
  .trip_hi(trip_hi), .fault_q(fault_q), .pwm_oe(pwm_oe)
);

// File: tb/pwm3_top_tb_top.sv
`timescale 1ns/1ps
module pwm3_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        trip_n = 1'b1;
  logic [5:0]  pwm_o, pwm_oe;

  int checks = 0;
  int fails  = 0;
  int hi_cnt [6];
  int comp_err;

  always #2.5 clk = ~clk;

  pwm3_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trip_n(trip_n), .pwm_o(pwm_o), .pwm_oe(pwm_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int n);
    for (int j = 0; j < 6; j++) hi_cnt[j] = 0;
    comp_err = 0;
    repeat (n) begin
      @(negedge clk);
      for (int j = 0; j < 6; j++) hi_cnt[j] += int'(pwm_o[j]);
      if (pwm_o[5:3] != ~pwm_o[2:0]) comp_err++;
    end
  endtask

  task automatic setup(input int p, input int d0, input int d1, input int d2);
    wr(0, p); wr(1, d0); wr(2, d1); wr(3, d2);
  endtask

  task automatic t_reset();
    chk(pwm_oe == 6'h00, "R10 oe after reset", pwm_oe, 0);
    chk(pwm_o[2:0] == 3'b000, "R10 idle level after reset", pwm_o[2:0], 0);
  endtask

  task automatic t_interior();
    setup(9, 3, 7, 1);
    wr(5, 6'h3F); wr(4, 1);
    idle(12);
    measure(50);
    chk(hi_cnt[0] == 15, "R2 phase0 duty 3/10", hi_cnt[0], 15);
    chk(hi_cnt[1] == 35, "R2 phase1 duty 7/10", hi_cnt[1], 35);
    chk(hi_cnt[2] == 5,  "R2 phase2 duty 1/10", hi_cnt[2], 5);
    chk(comp_err == 0, "R3 inverse pins", comp_err, 0);
    chk(pwm_oe == 6'h3F, "R5 all enables", pwm_oe, 63);
  endtask

  task automatic t_bounds();
    setup(9, 0, 9, 20);
    idle(12);
    measure(50);
    chk(hi_cnt[0] == 0,  "R4 duty 0 inactive", hi_cnt[0], 0);
    chk(hi_cnt[1] == 50, "R4 duty=P active", hi_cnt[1], 50);
    chk(hi_cnt[2] == 50, "R4 duty>P active", hi_cnt[2], 50);
    chk(comp_err == 0, "R3 inverse pins at bounds", comp_err, 0);
  endtask

  task automatic t_wrap();
    int last = -1;
    int gap_err = 0;
    int rises = 0;
    int sync_err = 0;
    logic [2:0] prev;
    setup(6, 2, 4, 5);
    idle(10);
    prev = pwm_o[2:0];
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (pwm_o[0] && !prev[0]) begin
        rises++;
        if (last >= 0 && (c - last) != 7) gap_err++;
        last = c;
        if (!(pwm_o[1] && !prev[1]) || !(pwm_o[2] && !prev[2])) sync_err++;
      end
      prev = pwm_o[2:0];
    end
    chk(rises >= 5, "R1 rises seen", rises, 5);
    chk(gap_err == 0, "R1 rise spacing P+1", gap_err, 0);
    chk(sync_err == 0, "R1 phases restart together", sync_err, 0);
  endtask

  task automatic t_polarity();
    setup(9, 3, 7, 1);
    wr(6, 0);
    idle(12);
    measure(50);
    chk(hi_cnt[0] == 35, "R9 low-active in-phase pin", hi_cnt[0], 35);
    chk(hi_cnt[3] == 15, "R9 inverse pin", hi_cnt[3], 15);
    wr(6, 1);
  endtask

  task automatic t_enable();
    wr(5, 6'h25);
    idle(1);
    chk(pwm_oe == 6'h25, "R5 enable mask", pwm_oe, 37);
    wr(5, 6'h3F);
  endtask

  task automatic t_stop();
    int changes = 0;
    logic [5:0] first;
    wr(4, 0);
    idle(2);
    first = pwm_o;
    chk(pwm_o == 6'b111000, "R8 idle levels when stopped", pwm_o, 56);
    repeat (20) begin
      @(negedge clk);
      if (pwm_o != first) changes++;
    end
    chk(changes == 0, "R8 outputs hold while stopped", changes, 0);
    wr(4, 1);
    idle(12);
    measure(50);
    chk(hi_cnt[0] == 15, "R8 restart resumes duty", hi_cnt[0], 15);
  endtask

  task automatic t_fault();
    @(negedge clk) trip_n = 1'b0;
    idle(5);
    chk(pwm_oe == 6'h00, "R6 trip forces high impedance", pwm_oe, 0);
    wr(4, 3);
    idle(3);
    chk(pwm_oe == 6'h00, "R7 clear ignored while trip low", pwm_oe, 0);
    @(negedge clk) trip_n = 1'b1;
    idle(5);
    chk(pwm_oe == 6'h00, "R7 fault sticky after trip release", pwm_oe, 0);
    wr(4, 3);
    idle(1);
    chk(pwm_oe == 6'h3F, "R7 clear while high releases", pwm_oe, 63);
  endtask

  initial begin : main
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_interior();
    t_bounds();
    t_wrap();
    t_polarity();
    t_enable();
    setup(9, 3, 7, 1);
    t_stop();
    t_fault();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule